// File: doc/BRIEF.md
# Scalar ALU with Carry and Zero Flags

This block is the arithmetic and logic stage of a small accumulator-style core. The core presents one operation at a time: an opcode and two data operands. The block combines the operands with its own carry flag, produces a result word and updates two status flags, carry and zero, which it holds between operations. The result set covers bitwise logic, addition and subtraction with and without carry, increment and decrement, single-bit shifts, rotates through carry, and a half-width multiply. Four further opcodes set or clear one flag directly and produce no result.

Operations enter on a valid/ready handshake and results leave through a one-entry output register on a second valid/ready handshake. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a consumer that holds `out_ready` low stalls the input side after one pending result. A result stays in place, unchanged, until it is taken. Both flags are also visible at all times on their own pins, so branch logic can read them.

Top module: `scalar_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted result-producing operation raises `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_carry` and `out_zero` hold their values.
- R2: Every result-producing operation sets the zero flag exactly when its DATA_W-bit result is all zeros. `out_zero` and `out_carry` equal the flag values left by that operation.
- R3: ADD (code 3) yields a+b and ADC (code 4) yields a+b+carry. Carry becomes the carry-out, so 0xFFFFFFFF+2 gives 1 with carry set, and 0+0 gives zero set with carry clear.
- R4: SUB (code 5) yields a-b and SBC (code 6) yields a-b-carry. Carry becomes the borrow, so 0-1 gives 0xFFFFFFFF with carry set, and an exact zero difference leaves carry clear.
- R5: INC (code 7) yields a+1 with carry as carry-out, so 0xFFFFFFFF gives 0 with carry and zero set. DEC (code 8) yields a-1 with carry as borrow, so 0 gives 0xFFFFFFFF with carry set and zero clear. Operand b is ignored.
- R6: LSL (code 9) moves bit DATA_W-1 of a into carry and fills bit 0 with 0. LSR (code 10) moves bit 0 of a into carry and fills the top bit with 0.
- R7: ROL (code 11) moves the old carry into bit 0 and bit DATA_W-1 of a into carry. ROR (code 12) moves the old carry into the top bit and bit 0 of a into carry.
- R8: MUL (code 13) gives the full DATA_W-bit product of the low DATA_W/2 bits of a and b, and clears carry. For example, 0x74E5 times 0xA483 gives 0x4B1E852F.
- R9: AND (code 0), OR (code 1) and XOR (code 2) give the bitwise result and leave the carry flag unchanged.
- R10: SETZ (14) and CLRZ (15) set and clear the zero flag. SETC (16) and CLRC (17) set and clear the carry flag. Each leaves the other flag unchanged and produces no output item. Codes 18 to 31 change nothing.
- R11: The flags change only on an edge where an operation is accepted. The opcode and operands on cycles without acceptance have no effect.
- R12: After reset both flags are clear, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 5 | Opcode, encoded as in R3 to R10 |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| out_valid | output | 1 | Result register holds an item |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_result | output | DATA_W | Result word |
| out_carry | output | 1 | Carry flag after this operation |
| out_zero | output | 1 | Zero flag after this operation |
| flag_carry | output | 1 | Current carry flag |
| flag_zero | output | 1 | Current zero flag |

## Verification
A result is due in the output register one edge after its operation is accepted. It stays there for as many further edges as `out_ready` is held low. The flag pins change on the same edge as the acceptance. The bench drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. Its scoreboard predicts each result at the moment of acceptance and compares it at the moment of transfer, so stalls never shift the expected values. Flag-only opcodes are checked on the flag pins in the cycle right after their acceptance.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_AND  = 5'd0,
    OP_OR   = 5'd1,
    OP_XOR  = 5'd2,
    OP_ADD  = 5'd3,
    OP_ADC  = 5'd4,
    OP_SUB  = 5'd5,
    OP_SBC  = 5'd6,
    OP_INC  = 5'd7,
    OP_DEC  = 5'd8,
    OP_LSL  = 5'd9,
    OP_LSR  = 5'd10,
    OP_ROL  = 5'd11,
    OP_ROR  = 5'd12,
    OP_MUL  = 5'd13,
    OP_SETZ = 5'd14,
    OP_CLRZ = 5'd15,
    OP_SETC = 5'd16,
    OP_CLRC = 5'd17
  } alu_op_e;

  typedef enum logic [1:0] {
    LM_AND = 2'd0,
    LM_OR  = 2'd1,
    LM_XOR = 2'd2,
    LM_MUL = 2'd3
  } lm_sel_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_ARITH = 2'd2,
    SRC_SHIFT = 2'd3
  } res_src_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] ext;

  // For subtraction the top bit of the extended difference is the borrow.
  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - EXT_W'(cin);
    else     ext = {1'b0, a} + {1'b0, b} + EXT_W'(cin);
  end

  assign res  = ext[DATA_W-1:0];
  assign cout = ext[DATA_W];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              left,
  input  logic              rotate,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic fill;

  assign fill = rotate & cin;

  always_comb begin
    if (left) begin
      res  = {a[DATA_W-2:0], fill};
      cout = a[DATA_W-1];
    end else begin
      res  = {fill, a[DATA_W-1:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu_logic_mul.sv
module alu_logic_mul
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lm_sel_e           sel,
  output logic [DATA_W-1:0] res
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] prod;

  generate
    if (HALF_W > 0) begin : g_mul
      logic [DATA_W-1:0] a_lo;
      logic [DATA_W-1:0] b_lo;
      assign a_lo = {{(DATA_W-HALF_W){1'b0}}, a[HALF_W-1:0]};
      assign b_lo = {{(DATA_W-HALF_W){1'b0}}, b[HALF_W-1:0]};
      assign prod = a_lo * b_lo;
    end else begin : g_nomul
      assign prod = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      LM_AND:  res = a & b;
      LM_OR:   res = a | b;
      LM_XOR:  res = a ^ b;
      default: res = prod;
    endcase
  end
endmodule

// File: rtl/scalar_alu.sv
module scalar_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_zero,
  output logic              flag_carry,
  output logic              flag_zero
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_op_e           op;
  logic              accept;
  logic              carry_q, zero_q;
  logic              carry_d, zero_d;
  logic              has_out;
  res_src_e          src;
  logic [DATA_W-1:0] res;

  // Operand routing for the sub-units
  lm_sel_e           lm_sel;
  logic [DATA_W-1:0] lm_res;
  logic [DATA_W-1:0] as_b;
  logic              as_cin, as_sub, as_cout;
  logic [DATA_W-1:0] as_res;
  logic              sh_left, sh_rot, sh_cout;
  logic [DATA_W-1:0] sh_res;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    lm_sel  = LM_AND;
    as_b    = in_b;
    as_cin  = 1'b0;
    as_sub  = 1'b0;
    sh_left = 1'b0;
    sh_rot  = 1'b0;
    src     = SRC_NONE;
    unique case (op)
      OP_AND: begin lm_sel = LM_AND; src = SRC_LOGIC; end
      OP_OR:  begin lm_sel = LM_OR;  src = SRC_LOGIC; end
      OP_XOR: begin lm_sel = LM_XOR; src = SRC_LOGIC; end
      OP_MUL: begin lm_sel = LM_MUL; src = SRC_LOGIC; end
      OP_ADD: src = SRC_ARITH;
      OP_ADC: begin as_cin = carry_q; src = SRC_ARITH; end
      OP_SUB: begin as_sub = 1'b1; src = SRC_ARITH; end
      OP_SBC: begin as_sub = 1'b1; as_cin = carry_q; src = SRC_ARITH; end
      OP_INC: begin as_b = ONE; src = SRC_ARITH; end
      OP_DEC: begin as_b = ONE; as_sub = 1'b1; src = SRC_ARITH; end
      OP_LSL: begin sh_left = 1'b1; src = SRC_SHIFT; end
      OP_LSR: src = SRC_SHIFT;
      OP_ROL: begin sh_left = 1'b1; sh_rot = 1'b1; src = SRC_SHIFT; end
      OP_ROR: begin sh_rot = 1'b1; src = SRC_SHIFT; end
      default: src = SRC_NONE;
    endcase
  end

  alu_logic_mul #(.DATA_W(DATA_W)) i_logic_mul (
    .a   (in_a),
    .b   (in_b),
    .sel (lm_sel),
    .res (lm_res)
  );

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a    (in_a),
    .b    (as_b),
    .cin  (as_cin),
    .sub  (as_sub),
    .res  (as_res),
    .cout (as_cout)
  );

  alu_shifter #(.DATA_W(DATA_W)) i_shifter (
    .a      (in_a),
    .cin    (carry_q),
    .left   (sh_left),
    .rotate (sh_rot),
    .res    (sh_res),
    .cout   (sh_cout)
  );

  // Result select and next flag values
  always_comb begin
    res     = '0;
    has_out = 1'b0;
    carry_d = carry_q;
    zero_d  = zero_q;
    unique case (src)
      SRC_LOGIC: begin
        res     = lm_res;
        has_out = 1'b1;
        if (op == OP_MUL) carry_d = 1'b0;
      end
      SRC_ARITH: begin
        res     = as_res;
        has_out = 1'b1;
        carry_d = as_cout;
      end
      SRC_SHIFT: begin
        res     = sh_res;
        has_out = 1'b1;
        carry_d = sh_cout;
      end
      default: begin
        if (op == OP_SETZ) zero_d  = 1'b1;
        if (op == OP_CLRZ) zero_d  = 1'b0;
        if (op == OP_SETC) carry_d = 1'b1;
        if (op == OP_CLRC) carry_d = 1'b0;
      end
    endcase
    if (has_out) zero_d = (res == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (accept) begin
      carry_q <= carry_d;
      zero_q  <= zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_zero   <= 1'b0;
    end else if (accept && has_out) begin
      out_valid  <= 1'b1;
      out_result <= res;
      out_carry  <= carry_d;
      out_zero   <= zero_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign flag_carry = carry_q;
  assign flag_zero  = zero_q;
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry,
  input logic              out_zero,
  input logic              flag_carry,
  input logic              flag_zero
);
  logic acc, acc_res, acc_logic;

  assign acc       = in_valid && in_ready;
  assign acc_res   = acc && (in_op <= 5'(OP_MUL));
  assign acc_logic = acc && (in_op <= 5'(OP_XOR));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_carry) && $stable(out_zero));

  assert_result_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_res |=> out_valid);

  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result == '0));

  assert_flags_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_res |=> flag_zero == out_zero && flag_carry == out_carry);

  assert_mul_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'(OP_MUL) |=> !flag_carry);

  assert_logic_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_logic |=> $stable(flag_carry));

  assert_setc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'(OP_SETC) |=> flag_carry && $stable(flag_zero));

  assert_clrz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'(OP_CLRZ) |=> !flag_zero && $stable(flag_carry));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(flag_carry) && $stable(flag_zero));

  logic unused_ok;
  assign unused_ok = ^{in_a, in_b};
endmodule

bind scalar_alu alu_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_scalar_alu.sv
module test_scalar_alu;
  import alu_pkg::*;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         c;
    logic         z;
    logic         has;
    logic [4:0]   op;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [4:0]   in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_carry, out_zero, flag_carry, flag_zero;

  int checks = 0, errors = 0;
  exp_t sb[$];
  logic m_c = 1'b0, m_z = 1'b0;
  logic stall_mode = 1'b0;
  logic [31:0] seed = 32'h1357_9BDF;
  logic [31:0] rdy_seed = 32'hC0FF_EE11;

  always #2 clk = ~clk;

  scalar_alu #(.DATA_W(W)) i_scalar_alu (.*);

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd2: return "R9";
      5'd3, 5'd4:       return "R3";
      5'd5, 5'd6:       return "R4";
      5'd7, 5'd8:       return "R5";
      5'd9, 5'd10:      return "R6";
      5'd11, 5'd12:     return "R7";
      5'd13:            return "R8";
      default:          return "R10";
    endcase
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [4:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic c, input logic z);
    exp_t e;
    logic [W:0] t;
    e.op = op; e.has = 1'b1; e.c = c; e.z = z; e.res = '0;
    case (op)
      5'd0: e.res = a & b;
      5'd1: e.res = a | b;
      5'd2: e.res = a ^ b;
      5'd3: begin t = a + b;           e.res = t[W-1:0]; e.c = t[W]; end
      5'd4: begin t = a + b + c;       e.res = t[W-1:0]; e.c = t[W]; end
      5'd5: begin e.res = a - b;       e.c = (a < b); end
      5'd6: begin e.res = a - b - c;   e.c = ({1'b0, a} < ({1'b0, b} + c)); end
      5'd7: begin e.res = a + 1;       e.c = (a == '1); end
      5'd8: begin e.res = a - 1;       e.c = (a == '0); end
      5'd9:  begin e.res = a << 1;     e.c = a[W-1]; end
      5'd10: begin e.res = a >> 1;     e.c = a[0]; end
      5'd11: begin e.res = (a << 1) | W'(c);           e.c = a[W-1]; end
      5'd12: begin e.res = (a >> 1) | ({c, {(W-1){1'b0}}}); e.c = a[0]; end
      5'd13: begin e.res = a[15:0] * b[15:0]; e.c = 1'b0; end
      default: begin
        e.has = 1'b0;
        if (op == 5'd14) e.z = 1'b1;
        if (op == 5'd15) e.z = 1'b0;
        if (op == 5'd16) e.c = 1'b1;
        if (op == 5'd17) e.c = 1'b0;
      end
    endcase
    if (e.has) e.z = (e.res == '0);
    return e;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v,
                       input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
    end
  endtask

  // Driver: presents one operation, predicts at acceptance, queues result
  task automatic send(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
      in_op = op; in_a = a; in_b = b;
    end
    e = model(op, a, b, m_c, m_z);
    m_c = e.c; m_z = e.z;
    if (e.has) sb.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic check_flags(input string tag);
    check(tag, W'(flag_carry), W'(m_c), "flag_carry");
    check(tag, W'(flag_zero),  W'(m_z), "flag_zero");
  endtask

  // out_ready generator
  initial begin
    forever begin
      @(negedge clk);
      rdy_seed = xs(rdy_seed);
      out_ready = stall_mode ? rdy_seed[3] : 1'b1;
    end
  end

  // Monitor: compares transfers against the scoreboard, checks holds
  initial begin
    logic         held = 1'b0;
    logic [W-1:0] h_res;
    logic         h_c, h_z;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held) begin
          check("R1", W'(out_valid), W'(1), "valid held");
          check("R1", out_result, h_res, "result held");
          check("R1", W'({out_carry, out_zero}), W'({h_c, h_z}), "flags held");
        end
        held = out_valid && !out_ready;
        h_res = out_result; h_c = out_carry; h_z = out_zero;
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check("R1", W'(1), W'(0), "unexpected output item");
          end else begin
            e = sb.pop_front();
            check(tag_of(e.op), out_result, e.res, $sformatf("result op %0d", e.op));
            check(tag_of(e.op), W'(out_carry), W'(e.c), $sformatf("carry op %0d", e.op));
            check("R2", W'(out_zero), W'(e.z), $sformatf("zero op %0d", e.op));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12", W'(flag_carry), W'(0), "carry after reset");
    check("R12", W'(flag_zero),  W'(0), "zero after reset");
    check("R12", W'(out_valid),  W'(0), "out_valid after reset");
    check("R12", W'(in_ready),   W'(1), "in_ready after reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R3 / R4 / R5 / R8 corner values
    send(5'd17, 0, 0);
    send(5'd5, 32'h0, 32'h1);            // R4: 0-1 -> FFFFFFFF, carry
    send(5'd5, 32'h1234, 32'h1234);      // R4: zero result, no borrow
    send(5'd3, 32'h0, 32'h0);            // R3: zero set, carry clear
    send(5'd3, 32'hFFFF_FFFF, 32'h2);    // R3: 1 with carry
    send(5'd7, 32'hFFFF_FFFF, 32'h55);   // R5
    send(5'd8, 32'h0, 32'hAA);           // R5
    send(5'd13, 32'hA3BF_74E5, 32'h03C7_A483); // R8
    send(5'd16, 0, 0);
    send(5'd4, 32'hA3BF_74E5, 32'h03C7_A483);  // R3 with carry in
    send(5'd16, 0, 0);
    send(5'd6, 32'hA3BF_74E5, 32'h03C7_A483);  // R4 with borrow in
    send(5'd16, 0, 0);
    send(5'd11, 32'hA3BF_74E5, 0);       // R7 rol with carry
    send(5'd17, 0, 0);
    send(5'd12, 32'hA3BF_74E5, 0);       // R7 ror without carry
    send(5'd16, 0, 0);
    send(5'd12, 32'hA3BF_74E5, 0);
    send(5'd9, 32'hA3BF_74E5, 0);        // R6
    send(5'd10, 32'hA3BF_74E5, 0);       // R6
    send(5'd16, 0, 0);
    send(5'd0, 32'hF0F0, 32'h0F0F);      // R9: zero result, carry kept
    check_flags("R9");

    // R10: flag-only operations on the flag pins
    send(5'd14, 0, 0); check_flags("R10");
    send(5'd17, 0, 0); check_flags("R10");
    send(5'd15, 0, 0); check_flags("R10");
    send(5'd16, 0, 0); check_flags("R10");
    send(5'd25, 32'hFFFF, 32'hFFFF); check_flags("R10");

    // R11: no acceptance means no flag change
    @(negedge clk);
    in_valid = 1'b0; in_op = 5'd17;
    repeat (3) @(negedge clk);
    #1;
    check_flags("R11");

    // Random coverage, first free-running, then with back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int n = 0; n < 400; n++) begin
        seed = xs(seed); ra = seed;
        seed = xs(seed); rb = seed;
        if (seed[7:6] == 2'b00) ra = '0;
        if (seed[9:8] == 2'b00) rb = ra;
        send(5'(seed[20:16] % 18), ra, rb);
      end
    end
    stall_mode = 1'b0;
    while (sb.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule